// File: doc/BRIEF.md
# Effective Address Generator

This block turns the addressing fields of an already decoded two-register instruction into an operand location or an operand value. It takes:

- a 4-bit mode code;
- the index of the first register and the read data of both registers;
- a signed constant field;
- the program counter;
- an operand-size code.

It returns one of three results: the effective address, the operand itself (for the immediate and register modes), or, for memory-indirect mode, an address read from memory through a simple read port.

For post-increment and pre-decrement modes the block also presents a register writeback. This is the register index and its stepped value. The register file commits it at the next clock edge.

All modes that need no memory complete combinationally in the cycle the request is presented. Memory-indirect mode issues one read and holds the unit busy until the read data has been registered. Requests presented while the unit is busy are dropped.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 0 (immediate): in the request cycle `ea_valid`=1, `is_operand`=1 and `ea_out` = the constant sign-extended to the address width.
- R2: Mode code 1 (register): in the request cycle `ea_valid`=1, `is_operand`=1 and `ea_out` = `ri_data`.
- R3: Mode code 2 (absolute) gives `ea_out` = sign-extended constant. Mode code 3 (register indirect) gives `ea_out` = `ri_data`. Both are valid in the request cycle with `is_operand`=0.
- R4: Mode code 5 gives `ri_data`+X. Mode code 6 gives `ri_data`+`rj_data`. Mode code 7 gives `ri_data`+`rj_data`+X. X is the sign-extended constant, and all sums wrap modulo 2^AW. All three are valid in the request cycle.
- R5: Mode code 8 (relative) gives `ea_out` = `pc`+X, where X is the constant taken as signed two's complement, valid in the request cycle.
- R6: Mode code 9 (post-increment): `ea_out` = `ri_data`, `wb_idx` = `ri_idx`, `wb_data` = `ri_data`+step.
- R7: Mode code 10 (pre-decrement): `wb_data` = `ri_data`-step and `ea_out` equals that decremented value.
- R8: The step is set by `op_size`: 0 gives 1 (byte), 1 gives 2 (16-bit), and both 2 and 3 give 4 (32-bit).
- R9: `wb_en` is 1 only for an accepted request in mode 9 or 10. For every other mode it is 0.
- R10: Mode code 4 (memory indirect):
  - In the request cycle `mem_req`=1, `mem_addr` = the sign-extended constant, and `ea_valid`=0.
  - `ea_valid` rises exactly one cycle after the cycle in which `mem_rvalid`=1, with `ea_out` = the returned data and `is_operand`=0.
- R11: Requests made while a memory-indirect access is in progress are ignored: no `ea_valid`, no `wb_en` and no `mem_req` before the indirect result.
- R12: Mode codes 11 to 15 are reserved and produce neither `ea_valid`, `wb_en` nor `mem_req`. After reset the outputs `ea_valid`, `wb_en` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe for one address computation |
| mode | input | 4 | Addressing mode code |
| ri_idx | input | RIW | Index of first register |
| ri_data | input | AW | Contents of first register |
| rj_data | input | AW | Contents of second register |
| disp | input | XW | Signed constant / displacement field |
| pc | input | AW | Current program counter |
| op_size | input | 2 | Operand size code |
| mem_req | output | 1 | Indirect-pointer read request |
| mem_addr | output | AW | Address of pointer read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | AW | Read data |
| ea_valid | output | 1 | Result valid strobe |
| ea_out | output | AW | Effective address or operand |
| is_operand | output | 1 | Result is an operand value, not an address |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | RIW | Writeback register index |
| wb_data | output | AW | Writeback value |

## Verification
The bench builds the unit with a 16-bit address, an 8-bit constant field and 3-bit register indices. With these values it can sweep every mode code, every size code and a set of boundary constants (0, ±1, +127, -128) against register values that include 0 and all-ones, so sign extension and modulo-2^16 wrap are both exercised. The memory-indirect path is driven with read latencies of zero to three cycles, while conflicting requests are injected during the wait.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [3:0] {
    MODE_IMM   = 4'd0,
    MODE_REG   = 4'd1,
    MODE_ABS   = 4'd2,
    MODE_RIND  = 4'd3,
    MODE_MIND  = 4'd4,
    MODE_IDX   = 4'd5,
    MODE_BIDX  = 4'd6,
    MODE_BIDXO = 4'd7,
    MODE_REL   = 4'd8,
    MODE_AINC  = 4'd9,
    MODE_ADEC  = 4'd10
  } mode_e;

  typedef enum logic [1:0] {
    IND_IDLE = 2'd0,
    IND_WAIT = 2'd1,
    IND_DONE = 2'd2
  } ind_st_e;

endpackage

// File: rtl/ea_gen_step.sv
module ea_gen_step #(
  parameter int AW = 32
) (
  input  logic [1:0]    op_size,
  output logic [AW-1:0] step
);
  always_comb begin
    unique case (op_size)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end
endmodule

// File: rtl/ea_gen_calc.sv
module ea_gen_calc
  import ea_gen_pkg::*;
#(
  parameter int AW = 32,
  parameter int XW = 16
) (
  input  logic [3:0]    mode,
  input  logic [XW-1:0] disp,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ptr_addr,
  output logic          direct_ok,
  output logic          indirect,
  output logic          opnd,
  output logic          wb_want,
  output logic [AW-1:0] wb_val
);
  localparam int EXT = AW - XW;

  logic [AW-1:0] sx;
  mode_e         m;

  assign sx       = {{EXT{disp[XW-1]}}, disp};
  assign m        = mode_e'(mode);
  assign ptr_addr = sx;

  always_comb begin
    addr      = '0;
    direct_ok = 1'b0;
    indirect  = 1'b0;
    opnd      = 1'b0;
    wb_want   = 1'b0;
    wb_val    = ra;
    case (m)
      MODE_IMM:   begin addr = sx;           direct_ok = 1'b1; opnd = 1'b1; end
      MODE_REG:   begin addr = ra;           direct_ok = 1'b1; opnd = 1'b1; end
      MODE_ABS:   begin addr = sx;           direct_ok = 1'b1; end
      MODE_RIND:  begin addr = ra;           direct_ok = 1'b1; end
      MODE_MIND:  begin addr = sx;           indirect  = 1'b1; end
      MODE_IDX:   begin addr = ra + sx;      direct_ok = 1'b1; end
      MODE_BIDX:  begin addr = ra + rb;      direct_ok = 1'b1; end
      MODE_BIDXO: begin addr = ra + rb + sx; direct_ok = 1'b1; end
      MODE_REL:   begin addr = pc + sx;      direct_ok = 1'b1; end
      MODE_AINC: begin
        addr      = ra;
        wb_val    = ra + step;
        wb_want   = 1'b1;
        direct_ok = 1'b1;
      end
      MODE_ADEC: begin
        wb_val    = ra - step;
        addr      = ra - step;
        wb_want   = 1'b1;
        direct_ok = 1'b1;
      end
      default: begin
        addr      = '0;
        direct_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ea_gen_ind.sv
module ea_gen_ind
  import ea_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rvalid,
  input  logic [AW-1:0] rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ptr_q
);
  ind_st_e st_q, st_d;
  logic    cap_en;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    case (st_q)
      IND_IDLE: if (start) st_d = IND_WAIT;
      IND_WAIT: if (rvalid) begin
        st_d   = IND_DONE;
        cap_en = 1'b1;
      end
      IND_DONE: st_d = IND_IDLE;
      default:  st_d = IND_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= IND_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) ptr_q <= rdata;
  end

  assign busy = (st_q != IND_IDLE);
  assign done = (st_q == IND_DONE);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == IND_IDLE)) else $error("start while busy"); // R11

  AST_IND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == IND_WAIT && rvalid) |=> done) else $error("late indirect result"); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held"); // R10
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_gen_pkg::*;
#(
  parameter int AW  = 32,
  parameter int XW  = 16,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [3:0]     mode,
  input  logic [RIW-1:0] ri_idx,
  input  logic [AW-1:0]  ri_data,
  input  logic [AW-1:0]  rj_data,
  input  logic [XW-1:0]  disp,
  input  logic [AW-1:0]  pc,
  input  logic [1:0]     op_size,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [AW-1:0]  mem_rdata,
  output logic           ea_valid,
  output logic [AW-1:0]  ea_out,
  output logic           is_operand,
  output logic           wb_en,
  output logic [RIW-1:0] wb_idx,
  output logic [AW-1:0]  wb_data
);
  logic          rst_meta_n, rst_sync_n;
  logic [AW-1:0] step, c_addr, c_ptr, c_wbv, ind_ea;
  logic          c_ok, c_ind, c_opnd, c_wb;
  logic          ind_busy, ind_done, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ea_gen_step #(.AW(AW)) u_step (
    .op_size (op_size),
    .step    (step)
  );

  ea_gen_calc #(.AW(AW), .XW(XW)) u_calc (
    .mode      (mode),
    .disp      (disp),
    .pc        (pc),
    .ra        (ri_data),
    .rb        (rj_data),
    .step      (step),
    .addr      (c_addr),
    .ptr_addr  (c_ptr),
    .direct_ok (c_ok),
    .indirect  (c_ind),
    .opnd      (c_opnd),
    .wb_want   (c_wb),
    .wb_val    (c_wbv)
  );

  assign accept = req && !ind_busy && rst_sync_n;

  ea_gen_ind #(.AW(AW)) u_ind (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (accept && c_ind),
    .rvalid (mem_rvalid),
    .rdata  (mem_rdata),
    .busy   (ind_busy),
    .done   (ind_done),
    .ptr_q  (ind_ea)
  );

  assign mem_req    = accept && c_ind;
  assign mem_addr   = c_ptr;
  assign ea_valid   = (accept && c_ok) || ind_done;
  assign ea_out     = ind_done ? ind_ea : c_addr;
  assign is_operand = accept && c_opnd;
  assign wb_en      = accept && c_wb;
  assign wb_idx     = ri_idx;
  assign wb_data    = c_wbv;

  AST_WB_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_en |-> (mode == MODE_AINC || mode == MODE_ADEC)) else $error("stray writeback"); // R9

  AST_ADEC_EA_IS_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_en && mode == MODE_ADEC) |-> (ea_out == wb_data)) else $error("predec mismatch"); // R7

  AST_AINC_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wb_en && mode == MODE_AINC) |-> ((wb_data - ea_out) == step)) else $error("postinc step"); // R6

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ind_busy && !ind_done) |-> (!ea_valid && !wb_en && !mem_req)) else $error("busy leak"); // R11

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode > 4'd10 && !ind_done) |-> (!ea_valid && !wb_en && !mem_req)) else $error("reserved mode acted"); // R12
endmodule

// File: tb/ea_gen_unit_bench.sv
module ea_gen_unit_bench;
  localparam int AW  = 16;
  localparam int XW  = 8;
  localparam int RIW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req;
  logic [3:0]     mode;
  logic [RIW-1:0] ri_idx;
  logic [AW-1:0]  ri_data, rj_data, pc;
  logic [XW-1:0]  disp;
  logic [1:0]     op_size;
  logic           mem_req, mem_rvalid;
  logic [AW-1:0]  mem_addr, mem_rdata;
  logic           ea_valid, is_operand, wb_en;
  logic [AW-1:0]  ea_out, wb_data;
  logic [RIW-1:0] wb_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  always #10 clk = ~clk;

  ea_gen_unit #(.AW(AW), .XW(XW), .RIW(RIW)) u_ea_gen_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ri_idx(ri_idx),
    .ri_data(ri_data), .rj_data(rj_data), .disp(disp), .pc(pc),
    .op_size(op_size), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ea_valid(ea_valid),
    .ea_out(ea_out), .is_operand(is_operand), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (mode=%0d size=%0d disp=%h ri=%h)",
               tag, act, exp, mode, op_size, disp, ri_data);
    end
  endtask

  function automatic logic [AW-1:0] sext(input logic [XW-1:0] v);
    return AW'($signed(v));
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [1:0] s);
    return (s == 2'd0) ? AW'(1) : (s == 2'd1) ? AW'(2) : AW'(4);
  endfunction

  task automatic check_direct();
    logic [AW-1:0] x, e, w;
    logic v, op, we;
    x = sext(disp); e = '0; w = '0; v = 1'b1; op = 1'b0; we = 1'b0;
    case (mode)
      4'd0:  begin e = x; op = 1'b1; end                      // R1
      4'd1:  begin e = ri_data; op = 1'b1; end                // R2
      4'd2:  e = x;                                           // R3
      4'd3:  e = ri_data;                                     // R3
      4'd5:  e = ri_data + x;                                 // R4
      4'd6:  e = ri_data + rj_data;                           // R4
      4'd7:  e = ri_data + rj_data + x;                       // R4
      4'd8:  e = pc + x;                                      // R5
      4'd9:  begin e = ri_data; w = ri_data + step_of(op_size); we = 1'b1; end  // R6 R8
      4'd10: begin w = ri_data - step_of(op_size); e = w; we = 1'b1; end        // R7 R8
      default: v = 1'b0;                                      // R12
    endcase
    chk("R12 valid", AW'(ea_valid), AW'(v));
    chk("R9 wb_en", AW'(wb_en), AW'(we));
    chk("R12 mem_req", AW'(mem_req), '0);
    if (v) begin
      chk("R1-R5 ea", ea_out, e);
      chk("R1 R2 is_operand", AW'(is_operand), AW'(op));
    end
    if (we) begin
      chk("R6 R7 wb_data", wb_data, w);
      chk("R6 wb_idx", AW'(wb_idx), AW'(ri_idx));
    end
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [XW-1:0] xs [6];
    logic [AW-1:0] rs [4];
    xs = '{8'h00, 8'h01, 8'hFF, 8'h7F, 8'h80, 8'h25};
    rs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h1234};
    rst_n = 1'b0; req = 1'b0; mode = '0; ri_idx = '0; ri_data = '0; rj_data = '0;
    disp = '0; pc = 16'h4000; op_size = '0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R12 reset valid", AW'(ea_valid), '0);
    chk("R12 reset wb_en", AW'(wb_en), '0);
    chk("R12 reset mem_req", AW'(mem_req), '0);

    // Sweep of all non-memory modes, sizes, constants and register values.
    for (int md = 0; md < 16; md++) begin
      if (md == 4) continue;
      for (int s = 0; s < 4; s++)
        for (int xi = 0; xi < 6; xi++)
          for (int ri = 0; ri < 4; ri++) begin
            @(negedge clk);
            req = 1'b1; mode = 4'(md); op_size = 2'(s); disp = xs[xi];
            ri_data = rs[ri]; rj_data = rs[3 - ri] ^ 16'h0F0F;
            ri_idx = 3'(md + ri); pc = 16'hFFF0 + 16'(xi);
            #2 check_direct();
          end
    end

    // Memory indirect with read latency 0..3 and blocked requests (R10, R11).
    for (int lat = 0; lat < 4; lat++) begin
      logic [AW-1:0] rd;
      rd = 16'hA500 + 16'(lat * 37);
      @(negedge clk);
      req = 1'b1; mode = 4'd4; disp = xs[lat + 1]; ri_data = 16'h0100;
      #2;
      chk("R10 mem_req", AW'(mem_req), 16'd1);
      chk("R10 mem_addr", mem_addr, sext(xs[lat + 1]));
      chk("R10 no early valid", AW'(ea_valid), '0);
      chk("R10 no wb", AW'(wb_en), '0);
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        req = 1'b1; mode = (w % 2 == 0) ? 4'd9 : 4'd4; op_size = 2'd2;
        #2;
        chk("R11 busy valid", AW'(ea_valid), '0);
        chk("R11 busy wb", AW'(wb_en), '0);
        chk("R11 busy mem_req", AW'(mem_req), '0);
      end
      @(negedge clk);
      req = 1'b1; mode = 4'd0; mem_rvalid = 1'b1; mem_rdata = rd;
      #2;
      chk("R11 wait valid", AW'(ea_valid), '0);
      @(negedge clk);
      req = 1'b0; mem_rvalid = 1'b0; mem_rdata = 16'hDEAD;
      #2;
      chk("R10 valid", AW'(ea_valid), 16'd1);
      chk("R10 ea", ea_out, rd);
      chk("R10 is_operand", AW'(is_operand), '0);
      @(negedge clk);
      #2;
      chk("R10 single valid", AW'(ea_valid), '0);
    end

    @(negedge clk); req = 1'b0;
    finish_run();
  end
endmodule